// File: doc/BRIEF.md
# Frame-Pulse Synchronous Serial Master

This block is a master-mode synchronous serial port that moves one word per frame in both directions at once. Each frame is introduced by a frame-sync output that is high for one full serial clock period, after which the word is sent most significant bit first. Word length can be set anywhere from 4 to 16 bits. The serial clock is produced from the system clock by a divider whose half period is set in system cycles.

A word is offered on a parallel transmit port with a valid/ready handshake. Its length and the clock divider are sampled when the frame starts. Outgoing bits change on rising serial clock edges, and incoming bits are taken on falling edges. When the last bit has been sampled, the received word is presented right-aligned with a one-cycle strobe. If another word is already waiting at that moment, the next frame follows without the serial clock going idle.

Top module: `tssp_master`

## Requirements
- R1: After reset, and whenever no frame is in progress, `sclk` and `fsync` are low and `tx_ready` is high.
- R2: A frame starts in the cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is low in the cycle after that, and it stays low until the last falling serial clock edge of the frame.
- R3: `fsync` rises together with a rising `sclk` edge and falls at the next rising `sclk` edge. It is high during exactly one serial period before the first data bit of each frame.
- R4: A frame carries `size_m1+1` bits of `tx_data`, taken from bit `size_m1` down to bit 0. `mosi` changes only on rising `sclk` edges.
- R5: `miso` is sampled on each falling data-bit edge. `rx_data` holds the `size_m1+1` sampled bits right-aligned, with the first bit sampled as the most significant, and zeros above them.
- R6: `rx_valid` is high for exactly one system cycle per frame, in the cycle after the last falling `sclk` edge of that frame.
- R7: Each high and each low phase of `sclk` lasts `half_div` system cycles, so the serial period is `2*half_div` cycles. `half_div` must be at least 1.
- R8: If `tx_valid` is high at the last falling edge of a frame, the next frame's `fsync` period starts one half period later, with no idle gap.
- R9: `sclk` toggles only inside frames, with `size_m1+2` rising edges per frame: one for the sync period and one for each bit.
- R10: Changing `size_m1` or `half_div` while a frame is in progress does not affect that frame's length or timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| half_div | input | CW | Serial half period in system cycles |
| size_m1 | input | 4 | Word length minus one |
| tx_data | input | 16 | Word to send, right-aligned |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word accepted when high together with valid |
| rx_data | output | 16 | Received word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| sclk | output | 1 | Serial clock |
| fsync | output | 1 | Frame-sync pulse |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Directed frames cover the shortest and the longest word lengths, each with the fastest divider and with a slower one. These cases separate off-by-one errors in bit count from errors in phase timing. A back-to-back pair whose lengths differ shows whether the length and divider are reloaded at the frame boundary and whether the idle gap is absent. Random words, lengths, dividers and chaining choices follow. Between frames, the size and divider inputs are scrambled while a frame runs; a mismatch in phase length or bit count then exposes any input that is not held from frame start. Independent transmit and slave patterns show any bit-order or alignment error in either direction.

// File: rtl/tssp_master.sv
module tssp_master #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] half_div,
  input  logic [3:0]    size_m1,
  input  logic [15:0]   tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic [15:0]   rx_data,
  output logic          rx_valid,
  output logic          sclk,
  output logic          fsync,
  output logic          mosi,
  input  logic          miso
);
  logic          busy;
  logic [CW-1:0] hdiv, cnt;
  logic [3:0]    len;
  logic [4:0]    ph;
  logic [15:0]   txs, rxs;
  logic          tick, last, load;

  assign tick     = busy && (cnt == hdiv - 1'b1);
  assign last     = tick && sclk && (ph == {1'b0, len} + 5'd1);
  assign tx_ready = !busy || last;
  assign load     = tx_valid && tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      hdiv     <= CW'(1);
      cnt      <= '0;
      len      <= '0;
      ph       <= '1;
      txs      <= '0;
      rxs      <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      sclk     <= 1'b0;
      fsync    <= 1'b0;
      mosi     <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (busy) begin
        if (!tick) begin
          cnt <= cnt + 1'b1;
        end else begin
          cnt <= '0;
          if (!sclk) begin
            sclk  <= 1'b1;
            ph    <= ph + 5'd1;
            fsync <= (ph == 5'h1F);
            if (ph == 5'h1F) begin
              mosi <= 1'b0;
            end else begin
              mosi <= txs[15];
              txs  <= txs << 1;
            end
          end else begin
            sclk <= 1'b0;
            if (ph != 5'd0) rxs <= {rxs[14:0], miso};
            if (last) begin
              rx_valid <= 1'b1;
              rx_data  <= {rxs[14:0], miso};
              busy     <= 1'b0;
            end
          end
        end
      end
      if (load) begin
        busy <= 1'b1;
        txs  <= tx_data << (4'd15 - size_m1);
        len  <= size_m1;
        hdiv <= (half_div == '0) ? CW'(1) : half_div;
        cnt  <= '0;
        ph   <= '1;
        rxs  <= '0;
      end
    end
  end
endmodule

// File: rtl/tssp_master_chk.sv
module tssp_master_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_valid,
  input logic tx_ready,
  input logic rx_valid,
  input logic sclk,
  input logic fsync,
  input logic mosi
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !tx_valid) |=> (!sclk && !fsync));

  assert_ready_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  assert_sync_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync) |-> $rose(sclk));

  assert_sync_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fsync) |-> $rose(sclk));

  assert_mosi_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> $rose(sclk));

  assert_strobe_after_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $fell(sclk));

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

bind tssp_master tssp_master_chk u_chk (.*);

// File: tb/tssp_master_bench.sv
`timescale 1ns/1ps
module tssp_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  half_div = 8'd1;
  logic [3:0]  size_m1 = 4'd0;
  logic [15:0] tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready, rx_valid, sclk, fsync, mosi;
  logic        miso = 1'b0;
  logic [15:0] rx_data;

  tssp_master #(.CW(8)) u_tssp_master (.*);

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [15:0] ex_tx [128];
  logic [15:0] sw    [128];
  logic [3:0]  ex_sz [128];
  int          ex_hd [128];
  bit          ex_bb [128];
  int nsent = 0, nf = 0, cur = 0, rf = 0;

  function automatic logic [15:0] mask(input logic [3:0] sz);
    return 16'((32'd1 << (sz + 1)) - 1);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  bit armed = 0, bad_t = 0, bad_s = 0;
  int sidx = 0, rises = 0, rise_cyc = 0, fall_cyc = 0;
  logic [15:0] got;

  always @(posedge sclk) begin
    #1;
    if (fsync && ex_bb[nf])
      check(cyc - fall_cyc == ex_hd[nf], "R8 no idle gap before chained frame", cyc - fall_cyc, ex_hd[nf]);
    if (armed) begin
      if (cyc - fall_cyc != ex_hd[cur]) bad_t = 1;
      rises++;
      miso = sw[cur][ex_sz[cur] - sidx];
    end
    rise_cyc = cyc;
  end

  always @(negedge sclk) begin
    #1;
    if (fsync && !armed) begin
      cur = nf; nf++;
      armed = 1; sidx = 0; got = '0; bad_t = 0; bad_s = 0; rises = 1;
      if (cyc - rise_cyc != ex_hd[cur]) bad_t = 1;
    end else if (armed) begin
      if (fsync) bad_s = 1;
      if (cyc - rise_cyc != ex_hd[cur]) bad_t = 1;
      got = {got[14:0], mosi};
      sidx++;
      if (sidx == int'(ex_sz[cur]) + 1) begin
        armed = 0;
        check(got == (ex_tx[cur] & mask(ex_sz[cur])), "R4 word sent MSB first", got, ex_tx[cur] & mask(ex_sz[cur]));
        check(!bad_t, "R7/R10 phase lengths follow latched divider", bad_t, 0);
        check(!bad_s, "R3 sync high only in first period", bad_s, 0);
        check(rises == int'(ex_sz[cur]) + 2, "R9 rising edges per frame", rises, ex_sz[cur] + 2);
      end
    end
    fall_cyc = cyc;
  end

  bit prev_v = 0;
  always @(negedge clk) begin
    if (rx_valid) begin
      check(rx_data == (sw[rf] & mask(ex_sz[rf])), "R5 received word right-aligned", rx_data, sw[rf] & mask(ex_sz[rf]));
      check(!prev_v, "R6 strobe lasts one cycle", prev_v, 0);
      rf++;
    end
    prev_v = rx_valid;
  end

  task automatic send(input logic [15:0] d, input logic [3:0] sz, input int hd, input logic [15:0] s, input bit bb);
    tx_valid = 1'b1; tx_data = d; size_m1 = sz; half_div = 8'(hd);
    while (!tx_ready) @(negedge clk);
    ex_tx[nsent] = d; ex_sz[nsent] = sz; ex_hd[nsent] = hd; sw[nsent] = s; ex_bb[nsent] = bb;
    nsent++;
    @(negedge clk);
    check(!tx_ready, "R2 ready low after accept", tx_ready, 0);
  endtask

  task automatic finish_frame();
    tx_valid = 1'b0;
    while (!tx_ready) begin
      size_m1 = 4'($urandom);
      half_div = 8'($urandom_range(1, 6));
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic idle_check();
    repeat (20) begin
      @(negedge clk);
      if (sclk || fsync || !tx_ready) begin
        check(0, "R1 idle outputs", {sclk, fsync, tx_ready}, 3'b001);
        return;
      end
    end
    check(1, "R1 idle outputs", 0, 0);
  endtask

  initial begin
    int unsigned seed = 32'h5eed_0042;
    void'($urandom(seed));
    repeat (4) @(negedge clk);
    check(!sclk && !fsync && tx_ready && !rx_valid, "R1 reset state",
          {sclk, fsync, tx_ready, rx_valid}, 4'b0010);
    rst_n = 1'b1;
    idle_check();
    send(16'hFFF5, 4'd3, 1, 16'h000A, 0);  finish_frame();
    send(16'hA5C3, 4'd15, 1, 16'h3C96, 0); finish_frame();
    send(16'h8001, 4'd15, 3, 16'hFFFF, 0); finish_frame();
    send(16'h0009, 4'd3, 2, 16'h0006, 0);  finish_frame();
    idle_check();
    send(16'h1234, 4'd15, 2, 16'hBEEF, 0);
    send(16'h000C, 4'd3, 1, 16'h0005, 1);
    send(16'h0155, 4'd8, 4, 16'h00AA, 1);
    finish_frame();
    for (int i = 0; i < 50; i++) begin
      bit bb = (i > 0) && ($urandom_range(0, 2) == 0);
      if (!bb) finish_frame();
      send(16'($urandom), 4'($urandom_range(3, 15)), $urandom_range(1, 4), 16'($urandom), bb);
    end
    finish_frame();
    idle_check();
    repeat (10) @(negedge clk);
    check(rf == nsent, "R6 one strobe per frame", rf, nsent);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired R2 actual=%0d expected=%0d", rf, nsent);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule